// File: doc/BRIEF.md
# Condition Code Flag Unit

This block sits beside an 8-bit accumulator datapath. It combines two 8-bit operands under a 3-bit operation code. The codes cover add, add with carry, subtract, subtract with borrow, AND, OR, XOR and load. The block drives the 8-bit result combinationally in the same cycle.

On each rising clock edge where the update enable is high, the block captures the status of that result into a condition code byte. The status flags are signed overflow, half carry, negative, zero and carry/borrow.

A global interrupt mask bit lives in the same byte. Two dedicated inputs set and clear it, independently of the update enable. The mask is also driven out on its own pin. A surrounding control unit reads the byte to decide branches, decimal fix-ups and interrupt acceptance.

Top module: `ccr_unit`

## Requirements
- R1: `result` is combinational from `a`, `b`, `op` and `cin`. The op codes give: 0 a+b, 1 a+b+cin, 2 a-b, 3 a-b-cin, 4 a&b, 5 a|b, 6 a^b, 7 b. `cin` has no effect for codes 0 and 2.
- R2: On codes 0 and 1, C (ccr bit 0) takes the carry out of bit 7 of the 8-bit sum.
- R3: On codes 2 and 3, C is set exactly when the unsigned `a` is less than `b` plus the borrow-in, and cleared otherwise.
- R4: On codes 0 to 3, V (ccr bit 7) is set exactly when the two's-complement result leaves the range -128..127.
- R5: On codes 0 and 1, H (ccr bit 4) takes the carry out of bit 3 into bit 4. Codes 2 to 7 leave H unchanged.
- R6: On every update, N (ccr bit 2) equals bit 7 of the result, and Z (ccr bit 1) is 1 exactly when the result is 0.
- R7: Codes 4 to 7 clear V and leave H and C unchanged.
- R8: While `upd_en` is low, V, H, N, Z and C keep their values at the clock edge.
- R9: I (ccr bit 3) becomes 1 on the edge after `set_i` is high. It becomes 0 after `clr_i` is high while `set_i` is low. `set_i` wins when both are high. Neither input depends on `upd_en`. `irq_masked` always equals I.
- R10: An asynchronous reset gives ccr = 8'h68 (I=1, all other flags 0) and `irq_masked` = 1.
- R11: ccr bits 6 and 5 always read as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| a | input | 8 | First operand (accumulator side) |
| b | input | 8 | Second operand |
| cin | input | 1 | Carry/borrow in, used by codes 1 and 3 |
| op | input | 3 | Operation code |
| upd_en | input | 1 | Capture arithmetic flags at this edge |
| set_i | input | 1 | Set interrupt mask |
| clr_i | input | 1 | Clear interrupt mask |
| result | output | 8 | Combinational operation result |
| ccr | output | 8 | {V,1,1,H,I,N,Z,C} |
| irq_masked | output | 1 | Interrupt mask state |

## Verification
Several kinds of operand pair are used, each telling apart a different pair of flags.
- Additions at 0x7F+0x01 and 0xFF+0x01 separate signed overflow from unsigned carry, and each also raises the half carry.
- A nibble-only carry (0x0F plus the carry-in) isolates H from C, and an add with `cin` high checks that plain add ignores it.
- Subtractions at 0x00-0x01, 0x80-0x01 and a borrow that just equals the minuend separate borrow, overflow and zero.
- Logical ops and load run with H and C preloaded to 1, to show that those flags persist.
- Randomized ops with random enable and mask controls cover the hold and priority rules.

// File: rtl/ccr_unit.sv
module ccr_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic       cin,
  input  logic [2:0] op,
  input  logic       upd_en,
  input  logic       set_i,
  input  logic       clr_i,
  output logic [7:0] result,
  output logic [7:0] ccr,
  output logic       irq_masked
);

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_ADC = 3'd1;
  localparam logic [2:0] OP_SUB = 3'd2;
  localparam logic [2:0] OP_SBC = 3'd3;
  localparam logic [2:0] OP_AND = 3'd4;
  localparam logic [2:0] OP_OR  = 3'd5;
  localparam logic [2:0] OP_XOR = 3'd6;
  localparam logic [2:0] OP_LD  = 3'd7;

  logic       ci;
  logic       is_add, is_sub;
  logic [8:0] add9, sub9;
  logic [4:0] nib;
  logic       ov_add, ov_sub;
  logic       f_v, f_h, f_i, f_n, f_z, f_c;

  assign ci     = (op == OP_ADC || op == OP_SBC) ? cin : 1'b0;
  assign is_add = (op == OP_ADD) || (op == OP_ADC);
  assign is_sub = (op == OP_SUB) || (op == OP_SBC);

  assign add9 = {1'b0, a} + {1'b0, b} + {8'd0, ci};
  assign sub9 = {1'b0, a} - {1'b0, b} - {8'd0, ci};
  assign nib  = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci};

  assign ov_add = (a[7] == b[7]) && (add9[7] != a[7]);
  assign ov_sub = (a[7] != b[7]) && (sub9[7] != a[7]);

  always_comb begin
    case (op)
      OP_ADD, OP_ADC: result = add9[7:0];
      OP_SUB, OP_SBC: result = sub9[7:0];
      OP_AND:         result = a & b;
      OP_OR:          result = a | b;
      OP_XOR:         result = a ^ b;
      OP_LD:          result = b;
      default:        result = b;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      f_v <= 1'b0;
      f_h <= 1'b0;
      f_n <= 1'b0;
      f_z <= 1'b0;
      f_c <= 1'b0;
    end else if (upd_en) begin
      f_n <= result[7];
      f_z <= (result == 8'd0);
      if (is_add) begin
        f_v <= ov_add;
        f_h <= nib[4];
        f_c <= add9[8];
      end else if (is_sub) begin
        f_v <= ov_sub;
        f_c <= sub9[8];
      end else begin
        f_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        f_i <= 1'b1;
    else if (set_i) f_i <= 1'b1;
    else if (clr_i) f_i <= 1'b0;
  end

  assign ccr        = {f_v, 2'b11, f_h, f_i, f_n, f_z, f_c};
  assign irq_masked = f_i;

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable({ccr[7], ccr[4], ccr[2:0]}));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> irq_masked);

  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !irq_masked);

  a_r6_zero: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ccr[1] == ($past(result) == 8'd0));

  a_r6_neg: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> ccr[2] == $past(result[7]));

  a_r7_logic: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op[2]) |=> (!ccr[7] && $stable(ccr[4]) && $stable(ccr[0])));

  a_r5_sub_keeps_h: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op[2:1] == 2'b01) |=> $stable(ccr[4]));

  a_r2_add_carry: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_ADD) |=> ccr[0] == ($past(result) < $past(a)));

endmodule

// File: tb/tb_ccr_unit.sv
module tb_ccr_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] a, b;
  logic       cin, upd_en, set_i, clr_i;
  logic [2:0] op;
  logic [7:0] result, ccr;
  logic       irq_masked;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] q_ccr[$];
  string      q_tag[$];

  bit m_v, m_h, m_i, m_n, m_z, m_c;

  always #5 clk = ~clk;

  ccr_unit dut (.clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .op(op),
                .upd_en(upd_en), .set_i(set_i), .clr_i(clr_i),
                .result(result), .ccr(ccr), .irq_masked(irq_masked));

  task automatic cmp8(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                      input logic ci, input logic up, input logic s, input logic cl,
                      input string tag);
    int k, sx, sy, r;
    logic [7:0] er;
    bit ev, eh, ec;
    @(negedge clk);
    op = o; a = x; b = y; cin = ci; upd_en = up; set_i = s; clr_i = cl;
    k  = (o == 3'd1 || o == 3'd3) ? int'(ci) : 0;
    sx = x[7] ? int'(x) - 256 : int'(x);
    sy = y[7] ? int'(y) - 256 : int'(y);
    ev = m_v; eh = m_h; ec = m_c;
    case (o)
      3'd0, 3'd1: begin
        r  = int'(x) + int'(y) + k;
        ec = r > 255;
        eh = (int'(x) % 16 + int'(y) % 16 + k) > 15;
        ev = (sx + sy + k > 127) || (sx + sy + k < -128);
      end
      3'd2, 3'd3: begin
        r  = int'(x) - int'(y) - k;
        ec = int'(x) < int'(y) + k;
        ev = (sx - sy - k > 127) || (sx - sy - k < -128);
      end
      3'd4: begin r = int'(x & y); ev = 0; end
      3'd5: begin r = int'(x | y); ev = 0; end
      3'd6: begin r = int'(x ^ y); ev = 0; end
      default: begin r = int'(y); ev = 0; end
    endcase
    er = r[7:0];
    #1;
    cmp8({"R1 result ", tag}, result, er);
    if (up) begin
      m_v = ev; m_h = eh; m_c = ec; m_n = er[7]; m_z = (er == 8'd0);
    end
    if (s) m_i = 1'b1;
    else if (cl) m_i = 1'b0;
    q_ccr.push_back({m_v, 2'b11, m_h, m_i, m_n, m_z, m_c});
    q_tag.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_ccr.size() > 0) begin
        logic [7:0] e;
        string t;
        e = q_ccr.pop_front();
        t = q_tag.pop_front();
        cmp8({"ccr ", t}, ccr, e);
        cmp8({"R9 irq_masked ", t}, {7'd0, irq_masked}, {7'd0, e[3]});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; a = 0; b = 0; cin = 0; op = 0; upd_en = 0; set_i = 0; clr_i = 0;
    m_v = 0; m_h = 0; m_i = 1; m_n = 0; m_z = 0; m_c = 0;
    repeat (3) @(negedge clk);
    cmp8("R10 R11 reset ccr", ccr, 8'h68);
    cmp8("R10 reset irq_masked", {7'd0, irq_masked}, 8'd1);
    rst = 1'b0;

    step(3'd0, 8'h7F, 8'h01, 0, 1, 0, 0, "R4 add overflow");
    step(3'd0, 8'hFF, 8'h01, 0, 1, 0, 0, "R2 add carry zero");
    step(3'd1, 8'h0F, 8'h00, 1, 1, 0, 0, "R5 adc half carry");
    step(3'd0, 8'h01, 8'h01, 1, 1, 0, 0, "R1 add ignores cin");
    step(3'd1, 8'hFF, 8'h00, 1, 1, 0, 0, "R2 adc carry via cin");
    step(3'd2, 8'h10, 8'h01, 0, 1, 0, 0, "R5 sub keeps H");
    step(3'd2, 8'h00, 8'h01, 0, 1, 0, 0, "R3 sub borrow");
    step(3'd3, 8'h05, 8'h05, 1, 1, 0, 0, "R3 sbc borrow edge");
    step(3'd3, 8'h05, 8'h04, 1, 1, 0, 0, "R6 sbc zero");
    step(3'd2, 8'h80, 8'h01, 0, 1, 0, 0, "R4 sub overflow");
    step(3'd0, 8'h8F, 8'h81, 0, 1, 0, 0, "R7 preload H C");
    step(3'd4, 8'hF0, 8'h0F, 0, 1, 0, 0, "R7 and");
    step(3'd5, 8'h80, 8'h01, 0, 1, 0, 0, "R7 or");
    step(3'd6, 8'h5A, 8'h5A, 0, 1, 0, 0, "R7 xor");
    step(3'd7, 8'h00, 8'h9C, 0, 1, 0, 0, "R7 load");
    step(3'd0, 8'hFF, 8'h01, 0, 0, 0, 0, "R8 hold");
    step(3'd2, 8'h00, 8'h01, 0, 0, 0, 1, "R9 clear");
    step(3'd0, 8'h00, 8'h00, 0, 0, 1, 1, "R9 set wins");
    step(3'd0, 8'h00, 8'h00, 0, 0, 0, 1, "R9 clear again");
    step(3'd0, 8'h00, 8'h00, 0, 1, 1, 0, "R9 set with update");

    for (int j = 0; j < 300; j++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[2:0], rv[10:3], rv[18:11], rv[19], rv[20] | rv[21], rv[22] & rv[23],
           rv[24], "R1 R8 random");
    end

    repeat (3) @(negedge clk);
    cmp8("queue drained", 8'(q_ccr.size()), 8'd0);
    finish_run();
  end
endmodule